// File: doc/BRIEF.md
# HDLC Receive Abort Detector

This block watches a bit-serial HDLC receive stream and works out where packets start and end. It finds flag patterns and tracks whether a packet is in progress. It reports an abort when a long run of 1 bits arrives in the middle of a packet. Bits are taken only on clock cycles where the bit strobe is high, so the block can sit behind a line interface that is slower than the core clock.

An abort sets a status bit that stays set until the status register is read. That bit drives an interrupt through two mask bits: one for this event and one for the whole HDLC group. A run of 1s on an idle line never counts as an abort. Once an abort has been seen, another one can only be recognised after a new flag. Zero-bit deletion, byte assembly, CRC checking and FIFO writes are handled elsewhere.

Top module: `hdlc_rx_abort_det`

## Requirements
- R1: `flag_o` pulses for one cycle on the clock edge that ends a strobe cycle in which the last eight accepted bits, oldest first, read 0,1,1,1,1,1,1,0. An accepted flag always drops `in_pkt_o`.
- R2: After a flag, `in_pkt_o` rises on the edge that ends the strobe cycle delivering the eighth following bit, provided no flag completed in between and that eighth bit does not complete a flag. Flags sent back to back keep `in_pkt_o` low.
- R3: When a packet is in progress, the seventh consecutive 1 bit makes `abort_o` pulse for one cycle on the edge that ends its strobe cycle. `in_pkt_o` falls on that same edge. A run of six 1s is not an abort.
- R4: A run of seven or more 1s while no packet is in progress raises neither `abort_o` nor `abt_stat_o`. If that run comes straight after a flag, the detector goes back to hunting, and the bit that follows does not start a packet.
- R5: One unbroken run of 1s gives at most one abort, however long it lasts.
- R6: After an abort, no further abort is recognised until a flag has been accepted.
- R7: `abt_stat_o` rises together with `abort_o` and stays high until a cycle with `rd_stat_i` high. It is low after that cycle's edge. If an abort arrives in the same cycle as the read, the bit stays set.
- R8: `irq_o` is high exactly when `abt_stat_o`, `abt_msk_i` and `grp_msk_i` are all 1. It follows the masks in the same cycle.
- R9: Cycles with `bit_en_i` low are ignored. They do not shift the flag window, extend a run of 1s or change the packet state.
- R10: While `rst_ni` is low, every output is 0. The flag window, the run counter, the packet state and the status bit are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial receive data bit |
| rd_stat_i | input | 1 | Status register read strobe |
| abt_msk_i | input | 1 | Abort event interrupt mask |
| grp_msk_i | input | 1 | HDLC group interrupt mask |
| in_pkt_o | output | 1 | Packet reception in progress |
| flag_o | output | 1 | Flag accepted (one-cycle pulse) |
| abort_o | output | 1 | Abort recognised (one-cycle pulse) |
| abt_stat_o | output | 1 | Latched abort status, cleared on read |
| irq_o | output | 1 | Masked abort interrupt |

## Verification
`flag_o`, `abort_o`, `in_pkt_o` and `abt_stat_o` are registered. Each changes on the clock edge that closes the strobe cycle, or read cycle, that caused it, so each is due one edge after the stimulus. `irq_o` is combinational from the status bit and the masks, so it is due in the same cycle as a mask change. The bench drives every input on the falling edge and samples on the next falling edge. Pulses are counted per stimulus segment, which holds their timing to the single edge after each strobe.

// File: rtl/hdlc_abt_pkg.sv
package hdlc_abt_pkg;
  localparam int unsigned FLAG_LEN = 8;
  localparam logic [FLAG_LEN-1:0] FLAG_DEF = 8'h7E;
  localparam int unsigned ABORT_RUN = 7;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_FLAG = 2'd1,
    ST_PKT  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hdlc_flag_det.sv
module hdlc_flag_det #(
  parameter int unsigned FLAG_W = hdlc_abt_pkg::FLAG_LEN,
  parameter logic [FLAG_W-1:0] FLAG_PAT = hdlc_abt_pkg::FLAG_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic flag_hit_o,
  output logic flag_o
);
  logic [FLAG_W-1:0] win_q;
  logic [FLAG_W-1:0] win_nxt;

  assign win_nxt    = {win_q[FLAG_W-2:0], bit_i};
  assign flag_hit_o = bit_en_i && (win_nxt == FLAG_PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (bit_en_i) win_q <= win_nxt;
      flag_o <= flag_hit_o;
    end
  end

  AST_FLAG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> !flag_o); // R1
endmodule

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int unsigned RUN_LEN = hdlc_abt_pkg::ABORT_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic run_hit_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  // fires once, on the bit that completes the run; saturation blocks repeats
  assign run_hit_o = bit_en_i && bit_i && (cnt_q == CNT_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_en_i) begin
      if (!bit_i)                cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_ONE_HIT_PER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_hit_o |=> !run_hit_o); // R5
endmodule

// File: rtl/hdlc_pkt_fsm.sv
module hdlc_pkt_fsm #(
  parameter int unsigned FLAG_W = hdlc_abt_pkg::FLAG_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic flag_hit_i,
  input  logic run_hit_i,
  output logic in_pkt_o,
  output logic abort_evt_o,
  output logic abort_o
);
  import hdlc_abt_pkg::*;

  localparam int unsigned BC_W = $clog2(FLAG_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(FLAG_W - 1);

  rx_state_e       state_q, state_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            armed_q, armed_d;

  assign abort_evt_o = run_hit_i && (state_q == ST_PKT) && armed_q;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    armed_d = armed_q;
    if (bit_en_i) begin
      if (flag_hit_i) begin
        state_d = ST_FLAG;
        bcnt_d  = '0;
        armed_d = 1'b1;
      end else if (run_hit_i) begin
        // long run of ones: abort inside a packet, idle line elsewhere
        state_d = ST_HUNT;
        if (abort_evt_o) armed_d = 1'b0;
      end else begin
        unique case (state_q)
          ST_FLAG: begin
            if (bcnt_q == BC_LAST) state_d = ST_PKT;
            else                   bcnt_d  = bcnt_q + 1'b1;
          end
          ST_PKT:  state_d = ST_PKT;
          default: state_d = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      armed_q <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      armed_q <= armed_d;
      abort_o <= abort_evt_o;
    end
  end

  assign in_pkt_o = (state_q == ST_PKT);

  AST_PKT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_o |-> armed_q); // R6
  AST_ABORT_ENDS_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_evt_o |=> !in_pkt_o); // R3
  AST_IDLE_WHEN_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(in_pkt_o)); // R9
endmodule

// File: rtl/hdlc_abt_status.sv
module hdlc_abt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_evt_i,
  input  logic rd_stat_i,
  input  logic abt_msk_i,
  input  logic grp_msk_i,
  output logic abt_stat_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          abt_stat_o <= 1'b0;
    else if (abort_evt_i) abt_stat_o <= 1'b1; // new event beats a read
    else if (rd_stat_i)   abt_stat_o <= 1'b0;
  end

  assign irq_o = abt_stat_o && abt_msk_i && grp_msk_i;

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i && !abort_evt_i |=> !abt_stat_o); // R7
  AST_STAT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abt_stat_o && !rd_stat_i |=> abt_stat_o); // R7
endmodule

// File: rtl/hdlc_rx_abort_det.sv
module hdlc_rx_abort_det #(
  parameter int unsigned FLAG_W = hdlc_abt_pkg::FLAG_LEN,
  parameter logic [FLAG_W-1:0] FLAG_PAT = hdlc_abt_pkg::FLAG_DEF,
  parameter int unsigned RUN_LEN = hdlc_abt_pkg::ABORT_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  input  logic rd_stat_i,
  input  logic abt_msk_i,
  input  logic grp_msk_i,
  output logic in_pkt_o,
  output logic flag_o,
  output logic abort_o,
  output logic abt_stat_o,
  output logic irq_o
);
  logic flag_hit;
  logic run_hit;
  logic abort_evt;

  hdlc_flag_det #(.FLAG_W(FLAG_W), .FLAG_PAT(FLAG_PAT)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .flag_hit_o(flag_hit), .flag_o(flag_o)
  );

  hdlc_ones_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .run_hit_o(run_hit)
  );

  hdlc_pkt_fsm #(.FLAG_W(FLAG_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .flag_hit_i(flag_hit), .run_hit_i(run_hit),
    .in_pkt_o(in_pkt_o), .abort_evt_o(abort_evt), .abort_o(abort_o)
  );

  hdlc_abt_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_evt_i(abort_evt),
    .rd_stat_i(rd_stat_i), .abt_msk_i(abt_msk_i), .grp_msk_i(grp_msk_i),
    .abt_stat_o(abt_stat_o), .irq_o(irq_o)
  );

  AST_ABORT_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(in_pkt_o)); // R4
  AST_ABORT_SETS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> abt_stat_o); // R7
  AST_FLAG_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_o && abort_o)); // R1
endmodule

// File: tb/hdlc_rx_abort_det_tb.sv
`timescale 1ns/1ps
module hdlc_rx_abort_det_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, bit_d = 1'b0, rd = 1'b0, m_abt = 1'b0, m_grp = 1'b0;
  logic in_pkt, flag, abort, stat, irq;

  int checks = 0;
  int errors = 0;
  int n_flag = 0;
  int n_abort = 0;

  always #2 clk = ~clk;

  hdlc_rx_abort_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .bit_i(bit_d),
    .rd_stat_i(rd), .abt_msk_i(m_abt), .grp_msk_i(m_grp),
    .in_pkt_o(in_pkt), .flag_o(flag), .abort_o(abort),
    .abt_stat_o(stat), .irq_o(irq)
  );

  // {bits[7:0], nbits[3:0], in_pkt after, flags seen[1:0], aborts seen[1:0]}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {8'h7E, 4'd8, 1'b0, 2'd1, 2'd0},  // opening flag (R1)
    {8'hA5, 4'd8, 1'b1, 2'd0, 2'd0},  // data enters packet (R2)
    {8'h7F, 4'd8, 1'b0, 2'd0, 2'd1},  // 0 + seven 1s: abort (R3)
    {8'hFF, 4'd8, 1'b0, 2'd0, 2'd0},  // run continues: once only (R5)
    {8'h7F, 4'd8, 1'b0, 2'd0, 2'd0},  // no flag since abort (R6, R4)
    {8'h7E, 4'd8, 1'b0, 2'd1, 2'd0},  // flag (R1)
    {8'h7F, 4'd7, 1'b0, 2'd0, 2'd0},  // seven 1s after flag: idle (R4)
    {8'h00, 4'd1, 1'b0, 2'd0, 2'd0},  // back to hunt, no packet (R4)
    {8'h7E, 4'd8, 1'b0, 2'd1, 2'd0},  // flag (R1)
    {8'h7E, 4'd8, 1'b0, 2'd1, 2'd0},  // back-to-back flag (R2)
    {8'h3C, 4'd8, 1'b1, 2'd0, 2'd0},  // data (R2)
    {8'h7E, 4'd8, 1'b0, 2'd1, 2'd0},  // closing flag, six 1s no abort (R3)
    {8'h00, 4'd8, 1'b1, 2'd0, 2'd0},  // data (R2)
    {8'h7F, 4'd8, 1'b0, 2'd0, 2'd1}   // exactly seven 1s in packet (R3)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on falling edge, strobe for one cycle, idle one cycle
  task automatic send_bit(input logic b, input logic rd_with);
    @(negedge clk);
    bit_en = 1'b1; bit_d = b; rd = rd_with;
    @(negedge clk);
    bit_en = 1'b0; rd = 1'b0;
    if (flag)  n_flag++;
    if (abort) n_abort++;
    @(negedge clk);
  endtask

  task automatic send_seq(input logic [7:0] bits, input int nb);
    for (int i = nb - 1; i >= 0; i--) send_bit(bits[i], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset in_pkt", int'(in_pkt), 0);
    chk("R10 reset stat", int'(stat), 0);
    chk("R10 reset irq", int'(irq), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      n_flag = 0; n_abort = 0;
      send_seq(VEC[v][16:9], int'(VEC[v][8:5]));
      chk($sformatf("R1,R2,R3,R4,R5,R6 vec %0d in_pkt", v), int'(in_pkt), int'(VEC[v][4]));
      chk($sformatf("R1 vec %0d flags", v), n_flag, int'(VEC[v][3:2]));
      chk($sformatf("R3,R4,R5,R6 vec %0d aborts", v), n_abort, int'(VEC[v][1:0]));
    end

    // R7: latched since the first abort, never read
    chk("R7 stat latched", int'(stat), 1);
    // R8: both masks needed, same cycle
    m_abt = 1'b1; m_grp = 1'b0; #1;
    chk("R8 irq grp masked", int'(irq), 0);
    m_abt = 1'b0; m_grp = 1'b1; #1;
    chk("R8 irq abt masked", int'(irq), 0);
    m_abt = 1'b1; #1;
    chk("R8 irq enabled", int'(irq), 1);
    // R7: read clears
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R7 stat cleared by read", int'(stat), 0);
    chk("R8 irq cleared by read", int'(irq), 0);
    repeat (3) @(negedge clk);
    chk("R7 stat stays clear", int'(stat), 0);

    // R9: strobe-low cycles ignored
    n_flag = 0; n_abort = 0;
    send_seq(8'h7E, 8);
    send_seq(8'h00, 8);
    chk("R2 in packet again", int'(in_pkt), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); bit_d = 1'b1; bit_en = 1'b0;
      @(negedge clk);
      if (abort) n_abort++;
      if (flag)  n_flag++;
    end
    chk("R9 in_pkt kept", int'(in_pkt), 1);
    chk("R9 no abort from unstrobed", n_abort, 0);
    send_seq(8'h3F, 6);
    chk("R9 unstrobed ones not counted", n_abort, 0);
    chk("R9 still in packet", int'(in_pkt), 1);
    // R7: abort in the same cycle as a read keeps the bit
    send_bit(1'b1, 1'b1);
    chk("R3 abort on seventh one", n_abort, 1);
    chk("R7 set beats read", int'(stat), 1);
    chk("R3 packet ended", int'(in_pkt), 0);
    chk("R8 irq after abort", int'(irq), 1);

    // R10: asynchronous reset mid-cycle
    #1 rst_ni = 1'b0; #0.5;
    chk("R10 async stat", int'(stat), 0);
    chk("R10 async irq", int'(irq), 0);
    chk("R10 async in_pkt", int'(in_pkt), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule